// File: doc/BRIEF.md
# USB IN Endpoint Transmit Control

This block holds the control and status state of one device-side USB IN endpoint. Firmware drives it through a byte-wide write strobe. Through that port it commits packets into a transmit buffer that holds one or two packets, aborts or discards packets, and requests a stall. It also clears the sticky event flags and the data toggle. The packet engine reports IN tokens and host ACKs. For each token the block answers, one cycle later, with the handshake or packet kind to send and the DATA0/DATA1 toggle to use.

The block counts committed packets, up to one or two depending on the buffering mode. It flips the toggle when the host acknowledges a packet and records stall and underrun events in sticky flags. An endpoint interrupt flag is raised when a packet completes or a flush is issued. The payload bytes live elsewhere: this logic only tracks how many complete packets are present.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, the packet count, every status flag, the toggle (0 = DATA0) and `rsp_valid` are all 0.
- R2: A write with bit 0 (load) set and bit 1 clear adds one packet. The count stops at 1 when `cfg_dbuf`=0 and at 2 when `cfg_dbuf`=1, and a load into a full buffer is ignored. `fifo_nonempty` is 1 exactly when the count is non-zero.
- R3: With no stall active and a packet present, an IN token yields `rsp_kind`=0 (DATA) with `rsp_odd` equal to the current toggle, in the cycle after the token. On a non-isochronous endpoint, a following `hs_ack` inverts the toggle, removes one packet and sets `ep_irq`.
- R4: An IN token with no packet present and no stall active sets the sticky `underrun` flag. On a non-isochronous endpoint it answers `rsp_kind`=1 (NAK). Write bit 4 as 1 to clear `underrun`; it holds otherwise.
- R5: While `stall_req` is 1 on a non-isochronous endpoint, every IN token yields `rsp_kind`=2 (STALL). Each such token sets the sticky `stalled` flag and empties the buffer. Write bit 3 as 1 to clear `stalled`. `stall_req` takes the value of write bit 2 on every write.
- R6: With `cfg_iso`=1, `stall_req` has no effect. A token with a packet present sends DATA and removes the packet with no ACK, sets `ep_irq` and leaves the toggle unchanged. A token with no packet present yields `rsp_kind`=3 (zero-length packet).
- R7: A write with bit 1 (flush) set and bit 0 clear removes one packet if any is present, and sets `ep_irq`. Two flushes are needed to empty a full double buffer.
- R8: A write with both bit 1 and bit 0 set aborts the load. The packet count stays as it was and `ep_irq` is set.
- R9: A write with bit 5 set forces the toggle to DATA0.
- R10: A write with bit 6 set clears `ep_irq`, unless an interrupt event occurs in the same cycle.
- R11: `hs_ack` has no effect unless a non-isochronous DATA response is awaiting its acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbuf | input | 1 | 1 = two-packet buffer, 0 = one packet |
| cfg_iso | input | 1 | 1 = isochronous endpoint |
| reg_wr | input | 1 | Control write strobe |
| reg_wdata | input | 7 | Control write data (bit meanings in R2 to R10) |
| tok_in | input | 1 | IN token received (one-cycle pulse) |
| hs_ack | input | 1 | Host ACK received (one-cycle pulse) |
| pkt_cnt | output | 2 | Packets held in the buffer |
| fifo_nonempty | output | 1 | At least one packet held |
| stall_req | output | 1 | Stall request as last written |
| stalled | output | 1 | Sticky: a STALL was sent |
| underrun | output | 1 | Sticky: a token found no packet |
| data_odd | output | 1 | Current toggle, 1 = DATA1 |
| ep_irq | output | 1 | Endpoint interrupt flag |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 2 | 0 DATA, 1 NAK, 2 STALL, 3 zero-length |
| rsp_odd | output | 1 | Toggle to use for the response |

## Verification
The hardest states to reach are those where several commands act on a buffer that already holds packets. Examples are a flush with a load in progress, a second flush of a full double buffer, and a STALL that must discard a packet committed before it. The stimulus gets there by first filling the buffer with plain load writes and reading `pkt_cnt`. It then applies the combined write, the repeated flush or the stall token, and the expected count follows from the count just read. A stray ACK is sent after a completed transfer, so that an ignored ACK shows up on the toggle.

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_dbuf,
  input  logic       cfg_iso,
  input  logic       reg_wr,
  input  logic [6:0] reg_wdata,
  input  logic       tok_in,
  input  logic       hs_ack,
  output logic [1:0] pkt_cnt,
  output logic       fifo_nonempty,
  output logic       stall_req,
  output logic       stalled,
  output logic       underrun,
  output logic       data_odd,
  output logic       ep_irq,
  output logic       rsp_valid,
  output logic [1:0] rsp_kind,
  output logic       rsp_odd
);
  localparam logic [1:0] K_DATA = 2'd0, K_NAK = 2'd1, K_STALL = 2'd2, K_ZLP = 2'd3;

  logic       ack_wait;
  logic [1:0] tok_kind, cnt_nx;

  wire [1:0] cap      = cfg_dbuf ? 2'd2 : 2'd1;
  wire       stall_on = stall_req & ~cfg_iso;
  wire       w_load   = reg_wr & reg_wdata[0];
  wire       w_flush  = reg_wr & reg_wdata[1];
  wire       ack_ok   = hs_ack & ack_wait;
  wire       t_stall  = tok_in & (tok_kind == K_STALL);
  wire       t_data   = tok_in & (tok_kind == K_DATA);
  wire       t_empty  = tok_in & ~stall_on & (pkt_cnt == 2'd0);

  assign fifo_nonempty = (pkt_cnt != 2'd0);
  assign tok_kind = stall_on ? K_STALL : fifo_nonempty ? K_DATA : cfg_iso ? K_ZLP : K_NAK;

  always_comb begin
    cnt_nx = pkt_cnt;
    if (t_stall) cnt_nx = 2'd0;
    else if (t_data && cfg_iso) cnt_nx = cnt_nx - 2'd1;
    if (ack_ok && cnt_nx != 2'd0) cnt_nx = cnt_nx - 2'd1;
    if (w_flush) begin
      if (!w_load && cnt_nx != 2'd0) cnt_nx = cnt_nx - 2'd1;
    end else if (w_load && cnt_nx < cap) begin
      cnt_nx = cnt_nx + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_cnt   <= 2'd0;
      stall_req <= 1'b0;
      stalled   <= 1'b0;
      underrun  <= 1'b0;
      data_odd  <= 1'b0;
      ep_irq    <= 1'b0;
      ack_wait  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_kind  <= K_DATA;
      rsp_odd   <= 1'b0;
    end else begin
      pkt_cnt   <= cnt_nx;
      if (reg_wr) stall_req <= reg_wdata[2];
      stalled   <= t_stall | (stalled & ~(reg_wr & reg_wdata[3]));
      underrun  <= t_empty | (underrun & ~(reg_wr & reg_wdata[4]));
      if (reg_wr && reg_wdata[5]) data_odd <= 1'b0;
      else if (ack_ok)            data_odd <= ~data_odd;
      ep_irq    <= ack_ok | (t_data & cfg_iso) | w_flush | (ep_irq & ~(reg_wr & reg_wdata[6]));
      if (t_data && !cfg_iso)   ack_wait <= 1'b1;
      else if (ack_ok || t_stall) ack_wait <= 1'b0;
      rsp_valid <= tok_in;
      if (tok_in) begin
        rsp_kind <= tok_kind;
        rsp_odd  <= data_odd;
      end
    end
  end

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt <= (cfg_dbuf ? 2'd2 : 2'd1)); // R2
  AST_STALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_STALL) |-> (stalled && pkt_cnt == 2'd0)); // R5
  AST_ISO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cfg_iso) |-> (rsp_kind != K_STALL)); // R6
  AST_NAK_FLAGS_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_NAK) |-> underrun); // R4
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(reg_wr && reg_wdata[4])) |=> underrun); // R4
  AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[5]) |=> !data_odd); // R9
  AST_FLUSH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[1]) |=> ep_irq); // R7
endmodule

// File: tb/test_usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module test_usb_in_ep_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dbuf = 1'b0, cfg_iso = 1'b0, reg_wr = 1'b0, tok_in = 1'b0, hs_ack = 1'b0;
  logic [6:0] reg_wdata = '0;
  logic [1:0] pkt_cnt, rsp_kind;
  logic fifo_nonempty, stall_req, stalled, underrun, data_odd, ep_irq, rsp_valid, rsp_odd;
  int errors = 0, checks = 0;
  bit sreq = 1'b0;
  bit [2:0] expq[$];

  usb_in_ep_ctrl i_usb_in_ep_ctrl (.*);

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) check("R3 unexpected response", 1, 0);
      else begin
        bit [2:0] e;
        e = expq.pop_front();
        check("R3/R4/R5/R6 response kind", rsp_kind, e[2:1]);
        check("R3 response toggle", rsp_odd, e[0]);
      end
    end
  end

  task automatic wr(input logic [6:0] d);
    reg_wr = 1'b1;
    reg_wdata = d | {4'b0, sreq, 2'b0};
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic tok(input logic [1:0] kind, input logic odd);
    expq.push_back({kind, odd});
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
  endtask

  task automatic ack();
    hs_ack = 1'b1;
    @(negedge clk);
    hs_ack = 1'b0;
  endtask

  initial begin
    #2000000;
    check("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 count", pkt_cnt, 0);
    check("R1 flags", {fifo_nonempty, stall_req, stalled, underrun, data_odd, ep_irq, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 empty token
    tok(2'd1, 1'b0);
    check("R4 underrun set", underrun, 1);
    @(negedge clk);
    check("R4 underrun sticky", underrun, 1);
    wr(7'h10);
    check("R4 underrun cleared", underrun, 0);

    // R2 load and single-buffer saturation
    wr(7'h01);
    check("R2 count after load", pkt_cnt, 1);
    check("R2 nonempty", fifo_nonempty, 1);
    wr(7'h01);
    check("R2 single saturates", pkt_cnt, 1);

    // R3 data then ack
    tok(2'd0, 1'b0);
    ack();
    check("R3 toggle after ack", data_odd, 1);
    check("R3 count after ack", pkt_cnt, 0);
    check("R3 irq after ack", ep_irq, 1);
    wr(7'h40);
    check("R10 irq cleared", ep_irq, 0);

    // R11 stray ack
    ack();
    check("R11 stray ack toggle", data_odd, 1);
    check("R11 stray ack irq", ep_irq, 0);

    // R3 DATA1 transfer
    wr(7'h01);
    tok(2'd0, 1'b1);
    ack();
    check("R3 toggle back", data_odd, 0);
    wr(7'h01);
    tok(2'd0, 1'b0);
    ack();
    check("R3 toggle DATA1", data_odd, 1);
    wr(7'h20);
    check("R9 toggle cleared", data_odd, 0);

    // R2/R7 double buffer
    cfg_dbuf = 1'b1;
    wr(7'h01); wr(7'h01); wr(7'h01);
    check("R2 double saturates", pkt_cnt, 2);
    wr(7'h40);
    wr(7'h02);
    check("R7 first flush", pkt_cnt, 1);
    check("R7 flush irq", ep_irq, 1);
    wr(7'h02);
    check("R7 second flush", pkt_cnt, 0);
    check("R7 empty", fifo_nonempty, 0);

    // R8 aborted load
    wr(7'h01);
    wr(7'h40);
    wr(7'h03);
    check("R8 abort keeps count", pkt_cnt, 1);
    check("R8 abort irq", ep_irq, 1);
    wr(7'h42);
    check("R7 flush to empty", pkt_cnt, 0);

    // R5 stall
    sreq = 1'b1;
    wr(7'h01);
    check("R5 stall_req set", stall_req, 1);
    tok(2'd2, 1'b0);
    check("R5 stalled flag", stalled, 1);
    check("R5 buffer emptied", pkt_cnt, 0);
    tok(2'd2, 1'b0);
    @(negedge clk);
    check("R5 stalled sticky", stalled, 1);
    sreq = 1'b0;
    wr(7'h08);
    check("R5 stalled cleared", stalled, 0);
    tok(2'd1, 1'b0);
    wr(7'h50);

    // R6 isochronous
    cfg_iso = 1'b1;
    sreq = 1'b1;
    wr(7'h01);
    tok(2'd0, 1'b0);
    check("R6 iso count", pkt_cnt, 0);
    check("R6 iso irq", ep_irq, 1);
    check("R6 iso no stalled", stalled, 0);
    tok(2'd3, 1'b0);
    check("R6 iso toggle kept", data_odd, 0);
    check("R6 iso underrun", underrun, 1);

    repeat (3) @(negedge clk);
    check("R3 all responses seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule